// File: doc/BRIEF.md
# Input Frame Handshake Controller

This block is the per-input sequencer that paces frame transfer between one rendering node and the double-buffered display store behind it. The node marks each new frame by flipping a single frame bit carried in the headers it draws into its video. Because nodes are allowed to swap during horizontal blanking, a frame can start anywhere in the raster. The controller therefore takes frame boundaries from that bit and not from the node's vertical sync. Headers whose parity check failed are not trusted and play no part in that decision.

Once a change of the frame bit has been accepted, the controller waits for the next vertical sync from the node. That sync proves that one whole refresh carrying the new bit has arrived. It then emits a one-cycle notify pulse, which an external serial back-channel forwards to the node. It then raises its barrier ready output and holds it. The ready outputs of all input units are combined outside the block (wired AND) and returned as the barrier input. When that barrier input is high during a vertical blanking strobe of the output display timing, which all inputs share, every unit toggles its bank select in the same cycle. Each unit drops its ready output at that moment and goes back to watching for the next frame.

Top module: `frame_handshake`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `notify`, `ready_out` and `bank_sel` are 0. The remembered frame bit starts at 0.
- R2: A new frame is accepted only while the unit is idle (not receiving, notifying or waiting at the barrier). It is accepted on a cycle with `hdr_valid`=1, `hdr_par_ok`=1 and `hdr_ab` different from the remembered frame bit, and the remembered bit then takes the value of `hdr_ab`. A header whose `hdr_ab` equals the remembered bit has no effect.
- R3: A header with `hdr_par_ok`=0 never starts a frame, whatever its `hdr_ab` value.
- R4: A frame counts as received at the first `src_vsync`=1 sampled in a cycle strictly after the cycle that accepted the frame. A `src_vsync` in the same cycle as the accepting header, or while the unit is idle, is ignored.
- R5: `notify` is high for exactly the one cycle after the completing `src_vsync` is sampled. `ready_out` rises in the cycle after `notify` and stays high until the swap.
- R6: A swap happens on a cycle where `ready_out`, `ready_in` and `out_vblank` are all 1. At that edge `bank_sel` toggles and `ready_out` falls. `bank_sel` never changes on any other cycle.
- R7: With `ready_out` high, `ready_in` without `out_vblank`, or `out_vblank` without `ready_in`, leaves `bank_sel` and `ready_out` unchanged.
- R8: Headers arriving while the unit is receiving, notifying or waiting at the barrier are ignored, whatever their `hdr_ab` value. After a swap, only a frame bit different from the last accepted value starts the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_valid | input | 1 | A decoded header is present this cycle |
| hdr_ab | input | 1 | Frame bit carried by the header |
| hdr_par_ok | input | 1 | Header parity check passed |
| src_vsync | input | 1 | One-cycle vertical sync strobe from the node's video |
| out_vblank | input | 1 | One-cycle vertical blanking strobe of the shared output timing |
| ready_in | input | 1 | Barrier: every input unit has its ready output high |
| ready_out | output | 1 | This unit has a full frame and waits for the swap |
| notify | output | 1 | One-cycle pulse toward the back-channel: frame received |
| bank_sel | output | 1 | Bank currently written by this input; the other bank is read |

## Verification
The bench targets a vertical sync that lands in the same cycle as the accepting header. A design that counted it would notify a frame that had not been fully received. The bench also sends headers with bad parity but a flipped frame bit, which a careless design would take as a new frame. It sends headers that repeat the old frame bit, which would re-trigger the handshake in a design that watched levels instead of changes. It sends flipped headers while the unit sits at the barrier, which a design that kept tracking the bit would take as a spurious extra frame. At the barrier, the bench holds `ready_in` alone, `out_vblank` alone, and both while the unit is not ready. Any of these would produce a premature or lone bank swap in a design that decoded the swap condition loosely.

// File: rtl/frame_handshake.sv
module frame_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic hdr_valid,
  input  logic hdr_ab,
  input  logic hdr_par_ok,
  input  logic src_vsync,
  input  logic out_vblank,
  input  logic ready_in,
  output logic ready_out,
  output logic notify,
  output logic bank_sel
);

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_RECV   = 2'd1,
    S_NOTIFY = 2'd2,
    S_HOLD   = 2'd3
  } phase_t;

  phase_t phase, phase_nx;
  logic   ab_seen;
  logic   new_frame;
  logic   swap_now;

  assign new_frame = (phase == S_IDLE) && hdr_valid && hdr_par_ok && (hdr_ab != ab_seen);
  assign swap_now  = (phase == S_HOLD) && ready_in && out_vblank;
  assign notify    = (phase == S_NOTIFY);
  assign ready_out = (phase == S_HOLD);

  always_comb begin
    phase_nx = phase;
    case (phase)
      S_IDLE:   if (new_frame) phase_nx = S_RECV;
      S_RECV:   if (src_vsync) phase_nx = S_NOTIFY;
      S_NOTIFY: phase_nx = S_HOLD;
      S_HOLD:   if (swap_now)  phase_nx = S_IDLE;
      default:  phase_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= S_IDLE;
      ab_seen  <= 1'b0;
      bank_sel <= 1'b0;
    end else begin
      phase <= phase_nx;
      if (new_frame) ab_seen  <= hdr_ab;
      if (swap_now)  bank_sel <= ~bank_sel;
    end
  end

  p_notify_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    notify |=> !notify);

  p_ready_follows_notify_r5: assert property (@(posedge clk) disable iff (!rst_n)
    notify |=> ready_out);

  p_notify_after_vsync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    notify |-> $past(src_vsync));

  p_ready_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_out && !(ready_in && out_vblank)) |=> (ready_out && $stable(bank_sel)));

  p_swap_clears_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_out && ready_in && out_vblank) |=> (!ready_out && (bank_sel != $past(bank_sel))));

  p_bank_only_on_barrier_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sel != $past(bank_sel)) |-> $past(ready_out && ready_in && out_vblank));

endmodule

// File: tb/tb_frame_handshake.sv
module tb_frame_handshake;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdr_valid = 1'b0, hdr_ab = 1'b0, hdr_par_ok = 1'b0;
  logic src_vsync = 1'b0, out_vblank = 1'b0, ready_in = 1'b0;
  logic ready_out, notify, bank_sel;

  always #2 clk = ~clk;

  frame_handshake dut (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ab(hdr_ab),
    .hdr_par_ok(hdr_par_ok), .src_vsync(src_vsync), .out_vblank(out_vblank),
    .ready_in(ready_in), .ready_out(ready_out), .notify(notify), .bank_sel(bank_sel)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string cur_req = "R1";

  // behavioural reference: step 0 idle, 1 collecting, 2 announcing, 3 parked
  int m_step = 0;
  int m_bit = 0;
  int m_bank = 0;
  int swaps = 0;
  int notifies = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_step = 0; m_bit = 0; m_bank = 0;
    end else begin
      if (m_step == 3) begin
        if (ready_in && out_vblank) begin m_bank = 1 - m_bank; m_step = 0; swaps++; end
      end else if (m_step == 2) begin
        m_step = 3; notifies++;
      end else if (m_step == 1) begin
        if (src_vsync) m_step = 2;
      end else begin
        if (hdr_valid && hdr_par_ok && (int'(hdr_ab) != m_bit)) begin
          m_bit = int'(hdr_ab); m_step = 1;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, "notify", int'(notify), (m_step == 2) ? 1 : 0);
      chk(cur_req, "ready_out", int'(ready_out), (m_step == 3) ? 1 : 0);
      chk(cur_req, "bank_sel", int'(bank_sel), m_bank);
    end
    if (cycles > 20000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input logic hv, input logic ha, input logic hp,
                      input logic sv, input logic vb, input logic ri);
    @(negedge clk); #1;
    hdr_valid = hv; hdr_ab = ha; hdr_par_ok = hp;
    src_vsync = sv; out_vblank = vb; ready_in = ri;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset notify", int'(notify), 0);
    chk("R1", "reset ready_out", int'(ready_out), 0);
    chk("R1", "reset bank_sel", int'(bank_sel), 0);
    @(negedge clk); #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", "post-reset ready_out", int'(ready_out), 0);

    cur_req = "R2";
    step(1, 0, 1, 0, 0, 0);       // same bit as remembered: no effect
    step(0, 0, 0, 1, 0, 0);       // vsync while idle
    idle(2);
    chk("R2", "no notify for old bit", notifies, 0);
    step(1, 1, 1, 0, 0, 0);       // flip accepted
    idle(3);
    chk("R2", "still collecting", int'(ready_out), 0);

    cur_req = "R4";
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    chk("R4", "notify after vsync", int'(notify), 1);

    cur_req = "R5";
    idle(1);
    chk("R5", "notify one cycle", int'(notify), 0);
    chk("R5", "ready_out high", int'(ready_out), 1);
    idle(4);
    chk("R5", "ready_out held", int'(ready_out), 1);

    cur_req = "R7";
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1);
    idle(1);
    chk("R7", "no swap yet", int'(bank_sel), 0);
    chk("R7", "ready kept", int'(ready_out), 1);

    cur_req = "R8";
    step(1, 0, 1, 0, 0, 0);       // flipped header while parked
    step(0, 0, 0, 1, 0, 0);
    idle(1);

    cur_req = "R6";
    step(0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0);
    chk("R6", "bank toggled", int'(bank_sel), 1);
    chk("R6", "ready cleared", int'(ready_out), 0);
    step(0, 0, 0, 0, 1, 1);       // barrier while idle: no swap
    idle(1);
    chk("R6", "no swap when idle", int'(bank_sel), 1);

    cur_req = "R3";
    step(1, 0, 0, 0, 0, 0);       // bad parity, flipped bit
    step(0, 0, 0, 1, 0, 0);
    idle(3);
    chk("R3", "bad parity ignored", int'(ready_out), 0);
    chk("R3", "notify count", notifies, 1);

    cur_req = "R4";
    step(1, 0, 1, 1, 0, 0);       // good flip with vsync in same cycle
    idle(3);
    chk("R4", "same-cycle vsync ignored", int'(ready_out), 0);
    step(0, 0, 0, 1, 0, 0);
    idle(2);
    chk("R4", "frame completes", int'(ready_out), 1);

    cur_req = "R6";
    step(0, 0, 0, 0, 1, 1);
    idle(1);
    chk("R6", "second swap", int'(bank_sel), 0);

    cur_req = "R8";
    step(1, 0, 1, 0, 0, 0);       // equals last accepted 0
    step(0, 0, 0, 1, 0, 0);
    idle(2);
    chk("R8", "stale bit after swap", notifies, 2);
    step(1, 1, 1, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    idle(2);
    chk("R8", "fresh bit starts frame", int'(ready_out), 1);
    step(0, 0, 0, 0, 1, 1);
    idle(2);
    chk("R6", "swap count", swaps, 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule